// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral built around a down-counter that runs at the input clock rate. Software talks to it over a simple synchronous register port. Through that port it loads the counter, sets an early-warning level, and starts or stops the count. It can also read the remaining count at any time and work out the time left.

Each change to a control register must be armed first. Software does this by writing a fixed unlock key to a dedicated key register. The arming is spent by the next write of any kind. A stray or runaway write therefore cannot silently stop or re-arm the watchdog.

Two events are recorded in a status word. The first is an early warning, raised when the remaining count meets a programmed threshold. The second is the expiry, raised when the count runs out. The interrupt lines follow these status bits. The register port cannot clear them. Only a separate privileged clear port can, and it uses a bit mask.

Top module: `kpw_timer`

## Requirements
- R1: After synchronous reset the counter, the threshold, the enable bit and both status bits read 0, and the key gate is locked.
- R2: Writing 0xF1D0DEAD to the key register (byte offset 0xC) unlocks the gate, and the next write to offset 0x0 (counter), 0x4 (threshold) or 0x8 (enable) takes effect at that clock edge.
- R3: The unlock is spent by the next register write. Writing any other value to the key register also locks the gate. Writes to 0x0, 0x4 or 0x8 made while locked change nothing.
- R4: Reading offset 0xC always returns 0. Reads never change the lock state.
- R5: An unlocked write to 0x8 sets the enable from data bit 0 (1 runs, 0 stops). Reading 0x8 returns the enable in bit 0, with all other bits 0.
- R6: While enabled, the counter drops by one per clock. While disabled, it holds. Reading 0x0 returns the present count.
- R7: An unlocked write to 0x0 loads the counter with the written value. A load wins over the decrement in the same cycle.
- R8: While enabled, with a nonzero threshold and a count equal to it, status bit 8 is set at the next edge. A threshold of 0 never sets bit 8.
- R9: While enabled with a count of 0, status bit 9 is set at the next edge and the counter stays at 0 until it is loaded.
- R10: A pulse on the clear port clears status bit 8 and/or bit 9 where the mask has that bit set. Other mask bits have no effect. A set condition in the same cycle wins over the clear.
- R11: The status word carries bit 8 and bit 9 only, with all other bits 0. The threshold and timeout interrupt outputs equal bits 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Byte address of the register (bits 3:2 select) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sec_clr | input | 1 | Privileged clear strobe |
| sec_clr_mask | input | 32 | Clear mask; bit 8 threshold, bit 9 timeout |
| irq_status | output | 32 | Status word; bit 8 threshold, bit 9 timeout |
| irq_thresh | output | 1 | Threshold (early warning) interrupt |
| irq_timeout | output | 1 | Timeout interrupt |

## Verification
The expiry condition and a privileged clear of bit 9 can land on the same edge. The bench provokes this by issuing the clear while the counter sits at 0 with counting still enabled. It judges the result by bit 9 staying set, and by bit 9 clearing only once the count has been stopped. A reload can also meet a decrement in the same cycle. The bench writes a new load value while the counter runs, then expects the written value on the next read rather than that value minus one, followed by a decrement on the read after.

// File: rtl/kpw_pkg.sv
`timescale 1ns/1ps
package kpw_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 4;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hF1D0_DEAD;

    // status word layout: one bit per event source, starting at THR_BIT
    localparam int unsigned THR_BIT  = 8;
    localparam int unsigned TMO_BIT  = 9;
    localparam int unsigned NUM_SRC  = 2;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_KEY    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        GATE_LOCKED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_e;

    typedef struct packed {
        logic              load;
        logic              thresh;
        logic              enable;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

    function automatic logic key_match(input logic [DATA_W-1:0] d);
        return d == UNLOCK_KEY;
    endfunction

endpackage

// File: rtl/kpw_keygate.sv
`timescale 1ns/1ps
module kpw_keygate
    import kpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_cmd_t           cmd,
    output gate_e             gate_q
);

    reg_sel_e sel;

    always_comb begin
        sel        = decode_sel(addr);
        cmd        = '0;
        cmd.data   = wdata;
        if (wr && gate_q == GATE_OPEN) begin
            case (sel)
                SEL_COUNT:  cmd.load   = 1'b1;
                SEL_THRESH: cmd.thresh = 1'b1;
                SEL_ENABLE: cmd.enable = 1'b1;
                default:    ;
            endcase
        end
    end

    // every write spends the gate; only the key itself re-opens it
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= GATE_LOCKED;
        end else if (wr) begin
            gate_q <= (sel == SEL_KEY && key_match(wdata)) ? GATE_OPEN : GATE_LOCKED;
        end
    end

endmodule

// File: rtl/kpw_counter.sv
`timescale 1ns/1ps
module kpw_counter
    import kpw_pkg::*;
#(
    parameter int unsigned CNT_W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] thr_q,
    output logic             run_q,
    output logic             hit_thr,
    output logic             hit_zero
);

    logic cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            thr_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (cmd.enable) run_q <= cmd.data[0];
            if (cmd.thresh) thr_q <= cmd.data[CNT_W-1:0];
            if (cmd.load) begin
                cnt_q <= cmd.data[CNT_W-1:0];
            end else if (run_q && !cnt_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign hit_thr  = run_q && (thr_q != '0) && (cnt_q == thr_q);
    assign hit_zero = run_q && cnt_zero;

endmodule

// File: rtl/kpw_irqstat.sv
`timescale 1ns/1ps
module kpw_irqstat
    import kpw_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned BASE = THR_BIT,
    parameter int unsigned W    = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_i,
    input  logic [W-1:0]    clr_mask,
    output logic [NSRC-1:0] stat_q
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[g] <= 1'b0;
            end else if (set_i[g]) begin
                stat_q[g] <= 1'b1;
            end else if (clr_i && clr_mask[BASE+g]) begin
                stat_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/kpw_timer.sv
`timescale 1ns/1ps
module kpw_timer
    import kpw_pkg::*;
#(
    parameter int unsigned CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sec_clr,
    input  logic [DATA_W-1:0] sec_clr_mask,
    output logic [DATA_W-1:0] irq_status,
    output logic              irq_thresh,
    output logic              irq_timeout
);

    localparam int unsigned SRC_THR = THR_BIT - THR_BIT;
    localparam int unsigned SRC_TMO = TMO_BIT - THR_BIT;

    wr_cmd_t          cmd;
    gate_e            gate_q;
    logic             key_open;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic             run_q;
    logic             hit_thr;
    logic             hit_zero;
    logic [NUM_SRC-1:0] ev_set;
    logic [NUM_SRC-1:0] stat_q;

    kpw_keygate u_gate (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cmd    (cmd),
        .gate_q (gate_q)
    );

    assign key_open = (gate_q == GATE_OPEN);

    kpw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cnt_q    (cnt_q),
        .thr_q    (thr_q),
        .run_q    (run_q),
        .hit_thr  (hit_thr),
        .hit_zero (hit_zero)
    );

    always_comb begin
        ev_set          = '0;
        ev_set[SRC_THR] = hit_thr;
        ev_set[SRC_TMO] = hit_zero;
    end

    kpw_irqstat #(.NSRC(NUM_SRC), .BASE(THR_BIT), .W(DATA_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_i    (ev_set),
        .clr_i    (sec_clr),
        .clr_mask (sec_clr_mask),
        .stat_q   (stat_q)
    );

    always_comb begin
        irq_status                     = '0;
        irq_status[THR_BIT +: NUM_SRC] = stat_q;
    end

    assign irq_thresh  = stat_q[SRC_THR];
    assign irq_timeout = stat_q[SRC_TMO];

    // key register never reads back
    always_comb begin
        case (decode_sel(reg_addr))
            SEL_COUNT:  reg_rdata = DATA_W'(cnt_q);
            SEL_THRESH: reg_rdata = DATA_W'(thr_q);
            SEL_ENABLE: reg_rdata = {{(DATA_W-1){1'b0}}, run_q};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kpw_timer_chk.sv
`timescale 1ns/1ps
module kpw_timer_chk
    import kpw_pkg::*;
#(
    parameter int unsigned CNT_W = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sec_clr,
    input logic [DATA_W-1:0] sec_clr_mask,
    input logic [DATA_W-1:0] irq_status,
    input logic              key_open,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  thr,
    input logic              run
);

    logic is_key_addr;
    logic loading;
    logic thr_cond;
    logic zero_cond;

    assign is_key_addr = (reg_addr[3:2] == 2'd3);
    assign loading     = reg_wr && key_open && (reg_addr[3:2] == 2'd0);
    assign thr_cond    = run && (thr != '0) && (cnt == thr);
    assign zero_cond   = run && (cnt == '0);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && thr == '0 && !run && irq_status == '0 && !key_open));

    p_key_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && is_key_addr && reg_wdata == UNLOCK_KEY) |=> key_open);

    p_locked_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !key_open && !is_key_addr) |=> ($stable(thr) && !key_open));

    p_key_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        is_key_addr |-> (reg_rdata == '0));

    p_decrement_r6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != '0 && !loading) |=> (cnt == $past(cnt) - 1'b1));

    p_thresh_sets_r8: assert property (@(posedge clk) disable iff (rst)
        thr_cond |=> irq_status[THR_BIT]);

    p_zero_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (zero_cond && !loading) |=> (cnt == '0 && irq_status[TMO_BIT]));

    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (zero_cond && sec_clr && sec_clr_mask[TMO_BIT]) |=> irq_status[TMO_BIT]);

    p_clear_thr_r10: assert property (@(posedge clk) disable iff (rst)
        (sec_clr && sec_clr_mask[THR_BIT] && !thr_cond) |=> !irq_status[THR_BIT]);

    p_status_bits_r11: assert property (@(posedge clk) disable iff (rst)
        ((irq_status & ~(32'h3 << THR_BIT)) == '0));

endmodule

bind kpw_timer kpw_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .sec_clr      (sec_clr),
    .sec_clr_mask (sec_clr_mask),
    .irq_status   (irq_status),
    .key_open     (key_open),
    .cnt          (cnt_q),
    .thr          (thr_q),
    .run          (run_q)
);

// File: tb/sim_kpw_timer.sv
`timescale 1ns/1ps
module sim_kpw_timer;

    localparam logic [2:0]  OP_W = 3'd0;  // register write
    localparam logic [2:0]  OP_R = 3'd1;  // register read compare
    localparam logic [2:0]  OP_C = 3'd2;  // privileged clear
    localparam logic [2:0]  OP_S = 3'd3;  // status compare {tmo,thr}
    localparam logic [31:0] KEY  = 32'hF1D0_DEAD;
    localparam logic [3:0]  A_CNT = 4'h0;
    localparam logic [3:0]  A_THR = 4'h4;
    localparam logic [3:0]  A_EN  = 4'h8;
    localparam logic [3:0]  A_KEY = 4'hC;
    localparam int NV = 63;

    // fields: op[74:72] addr[71:68] data[67:36] exp[35:4] req[3:0]
    localparam logic [74:0] VEC [NV] = '{
        {OP_R, A_CNT, 32'd0,   32'd0,   4'd1},   // R1
        {OP_S, A_CNT, 32'd0,   32'd0,   4'd1},   // R1
        {OP_W, A_CNT, 32'd100, 32'd0,   4'd3},   // R3 locked write
        {OP_R, A_CNT, 32'd0,   32'd0,   4'd3},
        {OP_W, A_KEY, KEY,     32'd0,   4'd2},   // R2
        {OP_W, A_CNT, 32'd100, 32'd0,   4'd2},
        {OP_R, A_CNT, 32'd0,   32'd100, 4'd2},
        {OP_W, A_CNT, 32'd200, 32'd0,   4'd3},   // R3 unlock spent
        {OP_R, A_CNT, 32'd0,   32'd100, 4'd3},
        {OP_W, A_KEY, KEY,     32'd0,   4'd3},
        {OP_W, A_KEY, 32'h1234,32'd0,   4'd3},   // R3 wrong key relocks
        {OP_W, A_CNT, 32'd300, 32'd0,   4'd3},
        {OP_R, A_CNT, 32'd0,   32'd100, 4'd3},
        {OP_W, A_KEY, KEY,     32'd0,   4'd4},
        {OP_R, A_KEY, 32'd0,   32'd0,   4'd4},   // R4 key hidden
        {OP_W, A_THR, 32'd7,   32'd0,   4'd4},   // R4 read kept unlock
        {OP_R, A_THR, 32'd0,   32'd7,   4'd4},
        {OP_W, A_KEY, KEY,     32'd0,   4'd8},
        {OP_W, A_THR, 32'd3,   32'd0,   4'd8},
        {OP_W, A_KEY, KEY,     32'd0,   4'd7},
        {OP_W, A_CNT, 32'd6,   32'd0,   4'd7},
        {OP_R, A_CNT, 32'd0,   32'd6,   4'd7},   // R7 load
        {OP_W, A_KEY, KEY,     32'd0,   4'd5},
        {OP_W, A_EN,  32'd1,   32'd0,   4'd5},   // R5 start
        {OP_R, A_CNT, 32'd0,   32'd6,   4'd6},   // R6
        {OP_R, A_CNT, 32'd0,   32'd5,   4'd6},
        {OP_S, A_CNT, 32'd0,   32'd0,   4'd8},   // count 4
        {OP_S, A_CNT, 32'd0,   32'd0,   4'd8},   // count 3 = thr
        {OP_S, A_CNT, 32'd0,   32'd1,   4'd8},   // R8 thr set
        {OP_R, A_CNT, 32'd0,   32'd1,   4'd6},
        {OP_S, A_CNT, 32'd0,   32'd1,   4'd9},   // count 0
        {OP_S, A_CNT, 32'd0,   32'd3,   4'd9},   // R9 tmo set
        {OP_R, A_CNT, 32'd0,   32'd0,   4'd9},   // R9 hold at 0
        {OP_R, A_EN,  32'd0,   32'd1,   4'd5},
        {OP_C, A_CNT, 32'h100, 32'd0,   4'd10},  // R10 clear thr
        {OP_S, A_CNT, 32'd0,   32'd2,   4'd10},
        {OP_C, A_CNT, 32'h200, 32'd0,   4'd10},  // R10 set beats clear
        {OP_S, A_CNT, 32'd0,   32'd2,   4'd10},
        {OP_W, A_KEY, KEY,     32'd0,   4'd5},
        {OP_W, A_EN,  32'd0,   32'd0,   4'd5},   // R5 stop
        {OP_R, A_EN,  32'd0,   32'd0,   4'd5},
        {OP_C, A_CNT, 32'h001, 32'd0,   4'd10},  // R10 other bits no effect
        {OP_S, A_CNT, 32'd0,   32'd2,   4'd10},
        {OP_C, A_CNT, 32'h200, 32'd0,   4'd10},
        {OP_S, A_CNT, 32'd0,   32'd0,   4'd10},
        {OP_W, A_KEY, KEY,     32'd0,   4'd6},
        {OP_W, A_CNT, 32'd50,  32'd0,   4'd6},
        {OP_R, A_CNT, 32'd0,   32'd50,  4'd6},   // R6 holds when stopped
        {OP_W, A_KEY, KEY,     32'd0,   4'd7},
        {OP_W, A_EN,  32'd1,   32'd0,   4'd7},
        {OP_W, A_KEY, KEY,     32'd0,   4'd7},   // 50 -> 49
        {OP_W, A_CNT, 32'd20,  32'd0,   4'd7},   // load beats decrement
        {OP_R, A_CNT, 32'd0,   32'd20,  4'd7},   // R7
        {OP_R, A_CNT, 32'd0,   32'd19,  4'd7},
        {OP_W, A_KEY, KEY,     32'd0,   4'd8},
        {OP_W, A_THR, 32'd0,   32'd0,   4'd8},   // threshold off
        {OP_W, A_KEY, KEY,     32'd0,   4'd8},
        {OP_W, A_CNT, 32'd2,   32'd0,   4'd8},
        {OP_R, A_CNT, 32'd0,   32'd2,   4'd8},
        {OP_R, A_CNT, 32'd0,   32'd1,   4'd8},
        {OP_S, A_CNT, 32'd0,   32'd0,   4'd8},   // R8 thr 0 never fires
        {OP_S, A_CNT, 32'd0,   32'd2,   4'd9},
        {OP_R, A_CNT, 32'd0,   32'd0,   4'd9}
    };

    logic        clk;
    logic        rst;
    logic [3:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sec_clr;
    logic [31:0] sec_clr_mask;
    logic [31:0] irq_status;
    logic        irq_thresh;
    logic        irq_timeout;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    kpw_timer u0 (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sec_clr      (sec_clr),
        .sec_clr_mask (sec_clr_mask),
        .irq_status   (irq_status),
        .irq_thresh   (irq_thresh),
        .irq_timeout  (irq_timeout)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // one op per clock; called just after a falling edge
    task automatic do_op(input logic [2:0] op, input logic [3:0] a, input logic [31:0] d,
                         input logic [31:0] e, input int req, input int idx);
        logic [31:0] act;
        logic [31:0] expw;
        reg_addr     = a;
        reg_wr       = (op == OP_W);
        reg_wdata    = d;
        sec_clr      = (op == OP_C);
        sec_clr_mask = d;
        #1;
        if (op == OP_R) begin
            n_checks++;
            if (reg_rdata !== e) begin
                n_fails++;
                $display("FAIL R%0d: step %0d read %h actual %h expected %h", req, idx, a, reg_rdata, e);
            end
        end else if (op == OP_S) begin
            // R11: status word and both interrupt lines must agree
            act  = irq_status | {30'd0, irq_timeout, irq_thresh};
            expw = (e[1:0] << 8) | {30'd0, e[1:0]};
            n_checks++;
            if (act !== expw) begin
                n_fails++;
                $display("FAIL R%0d/R11: step %0d status actual %h expected %h", req, idx, act, expw);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        sec_clr = 1'b0; sec_clr_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][74:72], VEC[i][71:68], VEC[i][67:36], VEC[i][35:4], int'(VEC[i][3:0]), i);
        end

        // R1: reset while running with timeout pending
        do_op(OP_W, A_KEY, KEY, 32'd0, 1, 100);
        do_op(OP_W, A_EN, 32'd1, 32'd0, 1, 101);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        do_op(OP_R, A_CNT, 32'd0, 32'd0, 1, 102);
        do_op(OP_R, A_THR, 32'd0, 32'd0, 1, 103);
        do_op(OP_R, A_EN,  32'd0, 32'd0, 1, 104);
        do_op(OP_S, A_CNT, 32'd0, 32'd0, 1, 105);
        do_op(OP_W, A_THR, 32'd9, 32'd0, 1, 106);   // R1 locked after reset
        do_op(OP_R, A_THR, 32'd0, 32'd0, 1, 107);

        // R8/R9: smallest load 1 with threshold 1
        do_op(OP_W, A_KEY, KEY, 32'd0, 8, 110);
        do_op(OP_W, A_THR, 32'd1, 32'd0, 8, 111);
        do_op(OP_W, A_KEY, KEY, 32'd0, 8, 112);
        do_op(OP_W, A_CNT, 32'd1, 32'd0, 8, 113);
        do_op(OP_W, A_KEY, KEY, 32'd0, 8, 114);
        do_op(OP_W, A_EN, 32'd1, 32'd0, 8, 115);
        do_op(OP_S, A_CNT, 32'd0, 32'd0, 8, 116);   // count 1 = thr
        do_op(OP_S, A_CNT, 32'd0, 32'd1, 8, 117);   // R8
        do_op(OP_S, A_CNT, 32'd0, 32'd3, 9, 118);   // R9
        do_op(OP_C, A_CNT, 32'h100, 32'd0, 10, 119);
        do_op(OP_S, A_CNT, 32'd0, 32'd2, 10, 120);  // R10

        reg_wr = 1'b0; sec_clr = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule